// File: doc/BRIEF.md
# Page-Mode DRAM Sequencer

This block sits between a simple valid/ready request port and an asynchronous fast-page-mode DRAM device. Each request carries a read/write flag, a full word address and (for writes) a data word. The address is split into a row half (upper bits) and a column half (lower bits). Both halves are sent to the device over one shared set of address pins: the row goes out as RAS falls, and the column follows before CAS falls. Every nanosecond timing limit is a parameter. The block rounds each one up to a whole number of clock periods at elaboration time.

Once a row is open it stays open. Later requests to the same row need only a fresh column and a one-clock CAS pulse, so a run of reads streams out one result every two clocks after a five-clock first access. A request to another row, an idle period of `IDLE_CLKS` clocks, or a pending refresh closes the row, and the RAS precharge time is then honoured before the next activation. A refresh request is held until the access in progress completes. It then runs as a CAS-before-RAS cycle, in which the device uses its own row counter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `resp_valid` are low, and `req_ready` is high.
- R2: The row is `req_addr[2*MUX_W-1:MUX_W]` and is on `dram_addr` when RAS falls. The column is `req_addr[MUX_W-1:0]` and is on `dram_addr` when CAS falls.
- R3: After RAS falls, CAS does not fall until RAS has been low for at least RCD clocks (11 ns rounded up to 2 clocks, never fewer than 2).
- R4: Once low, RAS stays low for at least 5 clocks (50 ns). Once high, RAS stays high for at least 3 clocks (30 ns) before it falls again.
- R5: A read accepted while no row is open gives a one-cycle `resp_valid` pulse 4 clock edges after the accepting edge, so the access takes five clocks counting the accept cycle. The data in that pulse is sampled 2 edges (13 ns rounded up) after CAS fell.
- R6: Reads to the open row, offered back to back, are accepted on the edge where the previous CAS rises. RAS stays low and the responses arrive 2 clocks apart (5-2-2-2).
- R7: For a write, `dram_we_n` is low and `dram_dq_oe` is high with the write data on `dram_dq_out` from the edge that presents the column until CAS rises. A write produces no `resp_valid`.
- R8: A request to a row other than the open one is held off. The row is closed, the precharge time is met, and the new row is then opened, with first-access latency as in R5.
- R9: If an open row sees no accepted request for `IDLE_CLKS` (8) clocks after its last CAS rise, RAS rises on the `IDLE_CLKS`-th edge.
- R10: A refresh drives CAS low while RAS is high, then drives RAS low for at least 5 clocks. During this cycle `dram_we_n` is high and `dram_dq_oe` is low. `ref_done` pulses for one cycle when RAS and CAS rise together, and stored data is unchanged.
- R11: A refresh request lets the access in progress finish and closes any open row before the CAS-before-RAS cycle. While the refresh is pending, no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (10 ns nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*MUX_W | Word address, row in upper half |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Read data valid (one cycle) |
| resp_rdata | output | DATA_W | Read data |
| ref_req | input | 1 | Refresh request pulse |
| ref_done | output | 1 | Refresh cycle finished (one cycle) |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to the device |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
The assertions assume that the device responds only through `dram_dq_in`, and that `ref_req` is a short pulse rather than a level held across many refresh cycles. The bench's device model keeps to these assumptions. It sends back read data only after the CAS-access delay and puts a poison word on the pins before that, so a capture made too early shows up as wrong data. Each refresh is requested with a single one-cycle pulse. Host requests are applied half a cycle away from the active edge and held until accepted, so the controller's own timing decides when requests are taken. That is what lets the bench check the exact latencies.

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
  parameter int MUX_W     = 10,
  parameter int DATA_W    = 16,
  parameter int CLK_NS    = 10,
  parameter int T_RCD_NS  = 11,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_CAS_NS  = 8,
  parameter int T_CAC_NS  = 13,
  parameter int IDLE_CLKS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [2*MUX_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 resp_valid,
  output logic [DATA_W-1:0]    resp_rdata,
  input  logic                 ref_req,
  output logic                 ref_done,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic                 dram_oe_n,
  output logic [MUX_W-1:0]     dram_addr,
  output logic [DATA_W-1:0]    dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DATA_W-1:0]    dram_dq_in
);

  localparam int RCD_RAW  = (T_RCD_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_RAW  = (T_RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int RP_RAW   = (T_RP_NS  + CLK_NS - 1) / CLK_NS;
  localparam int CAS_RAW  = (T_CAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int CAC_RAW  = (T_CAC_NS + CLK_NS - 1) / CLK_NS;
  localparam int RCD_CLKS = (RCD_RAW < 2) ? 2 : RCD_RAW;
  localparam int RAS_CLKS = (RAS_RAW < 1) ? 1 : RAS_RAW;
  localparam int RP_CLKS  = (RP_RAW  < 1) ? 1 : RP_RAW;
  localparam int CAS_CLKS = (CAS_RAW < 1) ? 1 : CAS_RAW;
  localparam int CAC_CLKS = (CAC_RAW < 1) ? 1 : CAC_RAW;
  localparam int IDLE_N   = (IDLE_CLKS < 1) ? 1 : IDLE_CLKS;
  localparam int CW       = $clog2(RCD_CLKS + RAS_CLKS + RP_CLKS + CAS_CLKS + IDLE_N + 2);

  typedef enum logic [2:0] {
    S_IDLE, S_RCD, S_COL, S_CAS, S_PAGE, S_RCAS, S_RRAS
  } state_t;

  state_t              st;
  logic [CW-1:0]       cnt, ras_cnt, pre_cnt, idle_cnt;
  logic [MUX_W-1:0]    open_row, col_q;
  logic [DATA_W-1:0]   wd_q;
  logic                cur_rd, ref_pend;
  logic [CAC_CLKS-1:0] rd_pipe;

  logic [MUX_W-1:0] row_of, col_of;
  logic hit, rd_busy, pre_ok, ras_ok, cas_last, page_ok, accept, close_now, launch;

  assign row_of   = req_addr[2*MUX_W-1:MUX_W];
  assign col_of   = req_addr[MUX_W-1:0];
  assign hit      = (row_of == open_row);
  assign rd_busy  = |rd_pipe;
  assign pre_ok   = (pre_cnt == CW'(RP_CLKS - 1));
  assign ras_ok   = (ras_cnt == CW'(RAS_CLKS - 1));
  assign cas_last = (st == S_CAS) && (cnt == '0);
  assign page_ok  = hit && !ref_pend && !(req_write && rd_busy);

  assign req_ready = ((st == S_IDLE) && pre_ok && !ref_pend) ||
                     ((cas_last || st == S_PAGE) && page_ok);
  assign accept    = req_valid && req_ready;

  assign close_now = (st == S_PAGE) && !accept && ras_ok && !rd_busy &&
                     (ref_pend || (req_valid && !hit) || (idle_cnt == CW'(IDLE_N - 1)));

  assign launch = cur_rd && (st == S_COL || (st == S_RCD && cnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      ras_cnt     <= '0;
      pre_cnt     <= CW'(RP_CLKS - 1);
      idle_cnt    <= '0;
      open_row    <= '0;
      col_q       <= '0;
      wd_q        <= '0;
      cur_rd      <= 1'b0;
      ref_pend    <= 1'b0;
      rd_pipe     <= '0;
      resp_valid  <= 1'b0;
      resp_rdata  <= '0;
      ref_done    <= 1'b0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      ref_done   <= 1'b0;
      resp_valid <= rd_pipe[CAC_CLKS-1];
      if (rd_pipe[CAC_CLKS-1]) resp_rdata <= dram_dq_in;
      rd_pipe[0] <= launch;
      for (int i = 1; i < CAC_CLKS; i++) rd_pipe[i] <= rd_pipe[i-1];
      if (ref_req) ref_pend <= 1'b1;
      if (!dram_ras_n && !ras_ok) ras_cnt <= ras_cnt + 1'b1;

      case (st)
        S_IDLE: begin
          if (pre_ok && ref_pend) begin
            dram_cas_n <= 1'b0;
            st         <= S_RCAS;
          end else if (accept) begin
            open_row   <= row_of;
            col_q      <= col_of;
            wd_q       <= req_wdata;
            cur_rd     <= !req_write;
            dram_addr  <= row_of;
            dram_ras_n <= 1'b0;
            ras_cnt    <= '0;
            cnt        <= CW'(RCD_CLKS - 1);
            st         <= S_RCD;
          end else if (!pre_ok) begin
            pre_cnt <= pre_cnt + 1'b1;
          end
        end
        S_RCD: begin
          if (cnt == '0) begin
            dram_cas_n <= 1'b0;
            cnt        <= CW'(CAS_CLKS - 1);
            st         <= S_CAS;
          end else begin
            cnt         <= cnt - 1'b1;
            dram_addr   <= col_q;
            dram_we_n   <= cur_rd;
            dram_oe_n   <= !cur_rd;
            dram_dq_oe  <= !cur_rd;
            dram_dq_out <= wd_q;
          end
        end
        S_COL: begin
          dram_cas_n <= 1'b0;
          cnt        <= CW'(CAS_CLKS - 1);
          st         <= S_CAS;
        end
        S_CAS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            dram_cas_n <= 1'b1;
            if (accept) begin
              dram_addr   <= col_of;
              dram_we_n   <= !req_write;
              dram_oe_n   <= req_write;
              dram_dq_oe  <= req_write;
              dram_dq_out <= req_wdata;
              cur_rd      <= !req_write;
              st          <= S_COL;
            end else begin
              dram_we_n  <= 1'b1;
              dram_dq_oe <= 1'b0;
              idle_cnt   <= '0;
              st         <= S_PAGE;
            end
          end
        end
        S_PAGE: begin
          if (accept) begin
            dram_addr   <= col_of;
            dram_we_n   <= !req_write;
            dram_oe_n   <= req_write;
            dram_dq_oe  <= req_write;
            dram_dq_out <= req_wdata;
            cur_rd      <= !req_write;
            st          <= S_COL;
          end else if (close_now) begin
            dram_ras_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            pre_cnt    <= '0;
            st         <= S_IDLE;
          end else if (idle_cnt != CW'(IDLE_N - 1)) begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        S_RCAS: begin
          dram_ras_n <= 1'b0;
          ras_cnt    <= '0;
          st         <= S_RRAS;
        end
        S_RRAS: begin
          if (ras_ok) begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            pre_cnt    <= '0;
            ref_done   <= 1'b1;
            ref_pend   <= ref_req;
            st         <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int RAS_CLKS = 5,
  parameter int RP_CLKS  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic dq_oe,
  input logic resp_valid
);

  logic [7:0] low_cnt, high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= 8'hFF;
    end else if (ras_n) begin
      low_cnt  <= '0;
      if (high_cnt != 8'hFF) high_cnt <= high_cnt + 1'b1;
    end else begin
      high_cnt <= '0;
      if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
    end
  end

  a_r3_rcd_met: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> (!$past(ras_n) && !$past(ras_n, 2)));

  a_r4_ras_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (low_cnt >= 8'(RAS_CLKS)));

  a_r4_ras_high_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_cnt >= 8'(RP_CLKS)));

  a_r7_we_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> dq_oe);

  a_r10_cbr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (we_n && !dq_oe));

  a_r5_row_held_for_data: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !ras_n);

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.RAS_CLKS(RAS_CLKS), .RP_CLKS(RP_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ras_n      (dram_ras_n),
  .cas_n      (dram_cas_n),
  .we_n       (dram_we_n),
  .dq_oe      (dram_dq_oe),
  .resp_valid (resp_valid)
);

// File: tb/test_fpm_dram_ctrl.sv
module test_fpm_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MW   = 4;
  localparam int DW   = 16;
  localparam int RCD  = 2;
  localparam int RASN = 5;
  localparam int RPN  = 3;
  localparam int IDLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, ref_req = 1'b0;
  logic [2*MW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, ref_done;
  logic [DW-1:0] resp_rdata;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [MW-1:0] addr;
  logic [DW-1:0] dq_out;
  logic [DW-1:0] dq_in = '0;

  fpm_dram_ctrl #(.MUX_W(MW), .DATA_W(DW)) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .ref_req(ref_req), .ref_done(ref_done),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  // device model
  logic [DW-1:0] mem [256];
  logic pras = 1'b1, pcas = 1'b1, cbr_arm = 1'b0, pend_rd = 1'b0;
  logic [MW-1:0] row_l = '0;
  logic [7:0] pend_idx = '0;
  int rlow = 0, rhigh = 100;
  int v_rcd = 0, v_ras = 0, v_rp = 0, v_wr = 0, n_refresh = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 16'hA000 | 16'(i);

  always @(negedge clk) begin
    if (pcas && !cas_n) begin
      if (ras_n) cbr_arm = 1'b1;
      else begin
        if (rlow < RCD) v_rcd++;
        if (!we_n) begin
          if (!dq_oe) v_wr++;
          mem[{row_l, addr}] = dq_out;
        end else begin
          dq_in = 16'hDEAD;
          pend_rd = 1'b1;
          pend_idx = {row_l, addr};
        end
      end
    end else if (pend_rd) begin
      dq_in = mem[pend_idx];
      pend_rd = 1'b0;
    end
    if (pras && !ras_n) begin
      if (rhigh < RPN) v_rp++;
      if (!cas_n && cbr_arm) n_refresh++;
      else row_l = addr;
      rlow = 1;
    end else if (!ras_n) rlow++;
    if (!pras && ras_n) begin
      if (rlow < RASN) v_ras++;
      rhigh = 1;
      cbr_arm = 1'b0;
    end else if (ras_n && rhigh < 100) rhigh++;
    pras = ras_n;
    pcas = cas_n;
  end

  // response and refresh monitors
  int nresp = 0, nref = 0, ref_cyc = 0;
  int resp_cyc [64];
  logic [DW-1:0] resp_dat [64];
  always @(negedge clk) begin
    if (resp_valid && nresp < 64) begin
      resp_cyc[nresp] = cyc;
      resp_dat[nresp] = resp_rdata;
      nresp++;
    end
    if (ref_done) begin
      ref_cyc = cyc;
      nref++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic send(input logic w, input logic [7:0] a, input logic [DW-1:0] d, output int acc);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin step(); end
    @(posedge clk);
    step();
    acc = cyc;
    req_valid = 1'b0;
  endtask

  task automatic wait_resp(input int n);
    for (int k = 0; k < 100 && nresp < n; k++) step();
  endtask

  task automatic t_reset();
    chk(ras_n === 1'b1, "R1 ras_n", 32'(ras_n), 1);
    chk(cas_n === 1'b1, "R1 cas_n", 32'(cas_n), 1);
    chk(we_n === 1'b1 && oe_n === 1'b1, "R1 we_n/oe_n", {we_n, oe_n}, 3);
    chk(dq_oe === 1'b0 && resp_valid === 1'b0, "R1 dq_oe/resp_valid", {dq_oe, resp_valid}, 0);
    chk(req_ready === 1'b1, "R1 req_ready", 32'(req_ready), 1);
  endtask

  task automatic t_first_read();
    int a, n0;
    n0 = nresp;
    send(1'b0, 8'h35, '0, a);
    wait_resp(n0 + 1);
    chk(nresp == n0 + 1 && resp_cyc[n0] == a + 4, "R5 first access latency", resp_cyc[n0] - a, 4);
    chk(resp_dat[n0] == 16'hA035, "R2 R5 row/col data", resp_dat[n0], 16'hA035);
  endtask

  task automatic t_burst();
    int a0, a, n0;
    repeat (14) step();
    n0 = nresp;
    send(1'b0, 8'h60, '0, a0);
    for (int i = 1; i < 4; i++) send(1'b0, 8'h60 + 8'(i), '0, a);
    wait_resp(n0 + 4);
    chk(resp_cyc[n0] == a0 + 4, "R5 burst head latency", resp_cyc[n0] - a0, 4);
    for (int i = 1; i < 4; i++) begin
      chk(resp_cyc[n0+i] - resp_cyc[n0+i-1] == 2, "R6 page hit spacing", resp_cyc[n0+i] - resp_cyc[n0+i-1], 2);
      chk(resp_dat[n0+i] == (16'hA060 + 16'(i)), "R6 page hit data", resp_dat[n0+i], 16'hA060 + 16'(i));
    end
  endtask

  task automatic t_write_read();
    int a, n0;
    repeat (14) step();
    send(1'b1, 8'h72, 16'h1234, a);
    step();
    chk(we_n === 1'b0 && dq_oe === 1'b1, "R7 we_n low with bus driven", {we_n, dq_oe}, 1);
    chk(dq_out == 16'h1234, "R7 write data on pins", dq_out, 16'h1234);
    n0 = nresp;
    repeat (3) step();
    chk(nresp == n0, "R7 write gives no response", nresp - n0, 0);
    send(1'b0, 8'h72, '0, a);
    wait_resp(n0 + 1);
    chk(resp_dat[n0] == 16'h1234, "R7 write read back", resp_dat[n0], 16'h1234);
    send(1'b0, 8'h94, '0, a);
    wait_resp(n0 + 2);
    chk(resp_dat[n0+1] == 16'hA094, "R8 row miss data", resp_dat[n0+1], 16'hA094);
    chk(resp_cyc[n0+1] == a + 4, "R8 reopen latency", resp_cyc[n0+1] - a, 4);
  endtask

  task automatic t_idle_close();
    int a;
    repeat (14) step();
    send(1'b0, 8'h11, '0, a);
    while (cyc < a + 3 + IDLE - 1) step();
    chk(ras_n === 1'b0, "R9 row still open before timeout", 32'(ras_n), 0);
    step();
    chk(ras_n === 1'b1, "R9 row closed at timeout", 32'(ras_n), 1);
  endtask

  task automatic t_refresh_idle();
    int r0, f0, n0, a;
    repeat (14) step();
    r0 = n_refresh; f0 = nref;
    ref_req = 1'b1; step(); ref_req = 1'b0;
    for (int k = 0; k < 40 && nref == f0; k++) step();
    chk(nref == f0 + 1, "R10 ref_done pulse", nref - f0, 1);
    chk(n_refresh == r0 + 1, "R10 CAS-before-RAS seen", n_refresh - r0, 1);
    n0 = nresp;
    send(1'b0, 8'h35, '0, a);
    wait_resp(n0 + 1);
    chk(resp_dat[n0] == 16'hA035, "R10 data kept", resp_dat[n0], 16'hA035);
  endtask

  task automatic t_refresh_open();
    int a1, a2, r0, n0;
    repeat (14) step();
    r0 = n_refresh; n0 = nresp;
    send(1'b0, 8'h61, '0, a1);
    ref_req = 1'b1; step(); ref_req = 1'b0;
    send(1'b0, 8'h62, '0, a2);
    wait_resp(n0 + 2);
    chk(n_refresh == r0 + 1, "R11 refresh done", n_refresh - r0, 1);
    chk(resp_cyc[n0] < ref_cyc, "R11 access finished before refresh", resp_cyc[n0], ref_cyc);
    chk(a2 > ref_cyc, "R11 request held while pending", a2, ref_cyc);
    chk(resp_dat[n0] == 16'hA061 && resp_dat[n0+1] == 16'hA062, "R11 data", resp_dat[n0+1], 16'hA062);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_first_read();
    t_burst();
    t_write_read();
    t_idle_close();
    t_refresh_idle();
    t_refresh_open();
    repeat (14) step();
    chk(v_rcd == 0, "R3 RAS-to-CAS violations", v_rcd, 0);
    chk(v_ras == 0, "R4 RAS low violations", v_ras, 0);
    chk(v_rp == 0, "R4 RAS high violations", v_rp, 0);
    chk(v_wr == 0, "R7 write without bus drive", v_wr, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule